// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a register-mapped front end for a fuse array that can be burned one bit at a time. Software drives a bank of 32-bit registers. One register selects a fuse word and another selects a bit inside it. A third supplies the value to burn. Three enable registers gate the path that reads a word back. A write to the program-enable register launches a single-bit burn. A per-bit written map enforces the rule that each fuse bit may be burned once. A later attempt on the same bit is refused, and the refusal shows on an error pulse.

The bus is a plain single-cycle port: a valid strobe, a write flag, a byte offset and write data. Read data is registered and appears after the clock edge that accepts the read. Burning goes through a two-state sequencer. `PG_IDLE` waits for an accepted program request and moves to `PG_JUDGE` (transition *accept*). `PG_JUDGE` looks up the target bit in the written map for exactly one cycle. It then returns to `PG_IDLE`, either committing the bit and setting its flag (transition *commit*) or leaving the array untouched and raising the error pulse (transition *refuse*).

At reset every word reads as all ones and the written map is empty. A serial number set by a parameter is placed at a chosen word, and its bitwise complement is placed at the word after it.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Byte offsets: data-out 0x00, word address 0x04, bit select 0x08, data-in 0x0C, chip enable 0x10, strobe 0x14, trim 0x18, program enable 0x1C, spare select 0x20, then storage registers test clock 0x24, test mode A 0x28, test mode B 0x2C, test control 0x30, test reference 0x34, program timing 0x38. A read presents its data on rsp_rdata after the clock edge that samples the request, and rsp_rdata holds that value until the next read.
- R2: The word address register keeps only its low log2(WORDS) bits (10 bits with the default 1024 words), and reads back masked.
- R3: A data-out read returns the fuse word at the current address when bit 0 of chip enable, strobe and trim are all 1. Otherwise it returns 0x000000FF.
- R4: Writes to the data-out offset change nothing and raise no error.
- R5: The program enable register stores only bit 0 of the written data. A write with bit 0 = 1 while spare select is 0 burns the bit at position bit-select[4:0] of the addressed word: to 1 if data-in is nonzero, to 0 if data-in is zero. The new word is readable from the second clock edge after the write.
- R6: Each fuse bit can be burned once. A second attempt on the same bit leaves the word unchanged and drives err_pulse high for the one cycle after the second edge following the write.
- R7: While spare select is nonzero, a program-enable write updates the register but burns no bit, sets no written flag and raises no error.
- R8: After reset every word is 0xFFFFFFFF, except word SERIAL_WORD (default 252), which holds SERIAL, and word SERIAL_WORD+1, which holds ~SERIAL. The written map is clear and all registers are 0.
- R9: Bit select, data-in, the three enables, spare select and the six storage registers keep all 32 written bits and read them back.
- R10: A read of an unmapped offset returns 0. A write to one changes nothing and drives err_pulse high for the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle flag for a refused burn or an unmapped write |

## Verification
The bench burns the same bit twice, in both directions. A design that dropped the written map would let the second burn flip the bit back, and one that kept a flag per word rather than per bit would refuse a burn on a neighbouring bit. It programs with spare select nonzero and then with it zero at the same bit. A design that set the flag anyway would refuse the second, legal burn. It drops one enable at a time to check for a wrong gate or a missing 0xFF value, and it writes the data-out and unmapped offsets to catch a stray write decode or a missing error pulse.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int WORD_W = 32;
    localparam int BIT_IDX_W = $clog2(WORD_W);

    typedef enum logic {
        PG_IDLE  = 1'b0,
        PG_JUDGE = 1'b1
    } prog_state_t;
endpackage

// File: rtl/otp_bus_regs.sv
module otp_bus_regs
    import otp_pkg::*;
#(
    parameter int         IDX_W      = 10,
    parameter logic [7:0] OFF_DOUT   = 8'h00,
    parameter logic [7:0] OFF_ADDR   = 8'h04,
    parameter logic [7:0] OFF_BITSEL = 8'h08,
    parameter logic [7:0] OFF_DIN    = 8'h0C,
    parameter logic [7:0] OFF_CE     = 8'h10,
    parameter logic [7:0] OFF_STB    = 8'h14,
    parameter logic [7:0] OFF_TRIM   = 8'h18,
    parameter logic [7:0] OFF_WREN   = 8'h1C,
    parameter logic [7:0] OFF_SPARE  = 8'h20,
    parameter logic [7:0] OFF_TCLK   = 8'h24,
    parameter logic [7:0] OFF_TMA    = 8'h28,
    parameter logic [7:0] OFF_TMB    = 8'h2C,
    parameter logic [7:0] OFF_TCTL   = 8'h30,
    parameter logic [7:0] OFF_TREF   = 8'h34,
    parameter logic [7:0] OFF_TPROG  = 8'h38
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [7:0]           req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    input  logic [WORD_W-1:0]    fuse_word,
    input  logic                 prog_reject,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 err_pulse,
    output logic [IDX_W-1:0]     word_addr,
    output logic [BIT_IDX_W-1:0] bit_sel,
    output logic                 bit_val,
    output logic                 prog_start,
    output logic                 rd_gate,
    output logic                 spare_nz
);
    logic [IDX_W-1:0]  addr_q;
    logic [WORD_W-1:0] bitsel_q, din_q, ce_q, stb_q, trim_q, spare_q;
    logic [WORD_W-1:0] tclk_q, tma_q, tmb_q, tctl_q, tref_q, tprog_q;
    logic              wren_q;
    logic [WORD_W-1:0] rd_val;
    logic              mapped;
    logic              wr_fire;

    assign wr_fire  = req_valid && req_write;
    assign rd_gate  = ce_q[0] && stb_q[0] && trim_q[0];
    assign spare_nz = |spare_q;

    always_comb begin
        rd_val = '0;
        mapped = 1'b1;
        case (req_addr)
            OFF_DOUT:   rd_val = rd_gate ? fuse_word : 32'h0000_00FF;
            OFF_ADDR:   rd_val = {{(WORD_W-IDX_W){1'b0}}, addr_q};
            OFF_BITSEL: rd_val = bitsel_q;
            OFF_DIN:    rd_val = din_q;
            OFF_CE:     rd_val = ce_q;
            OFF_STB:    rd_val = stb_q;
            OFF_TRIM:   rd_val = trim_q;
            OFF_WREN:   rd_val = {{(WORD_W-1){1'b0}}, wren_q};
            OFF_SPARE:  rd_val = spare_q;
            OFF_TCLK:   rd_val = tclk_q;
            OFF_TMA:    rd_val = tma_q;
            OFF_TMB:    rd_val = tmb_q;
            OFF_TCTL:   rd_val = tctl_q;
            OFF_TREF:   rd_val = tref_q;
            OFF_TPROG:  rd_val = tprog_q;
            default:    mapped = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            bitsel_q <= '0;
            din_q    <= '0;
            ce_q     <= '0;
            stb_q    <= '0;
            trim_q   <= '0;
            wren_q   <= 1'b0;
            spare_q  <= '0;
            tclk_q   <= '0;
            tma_q    <= '0;
            tmb_q    <= '0;
            tctl_q   <= '0;
            tref_q   <= '0;
            tprog_q  <= '0;
        end else if (wr_fire) begin
            case (req_addr)
                OFF_ADDR:   addr_q   <= req_wdata[IDX_W-1:0];
                OFF_BITSEL: bitsel_q <= req_wdata;
                OFF_DIN:    din_q    <= req_wdata;
                OFF_CE:     ce_q     <= req_wdata;
                OFF_STB:    stb_q    <= req_wdata;
                OFF_TRIM:   trim_q   <= req_wdata;
                OFF_WREN:   wren_q   <= req_wdata[0];
                OFF_SPARE:  spare_q  <= req_wdata;
                OFF_TCLK:   tclk_q   <= req_wdata;
                OFF_TMA:    tma_q    <= req_wdata;
                OFF_TMB:    tmb_q    <= req_wdata;
                OFF_TCTL:   tctl_q   <= req_wdata;
                OFF_TREF:   tref_q   <= req_wdata;
                OFF_TPROG:  tprog_q  <= req_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            err_pulse <= 1'b0;
        end else begin
            if (req_valid && !req_write) rsp_rdata <= rd_val;
            err_pulse <= (wr_fire && !mapped) || prog_reject;
        end
    end

    assign prog_start = wr_fire && (req_addr == OFF_WREN) && req_wdata[0] && !spare_nz;
    assign word_addr  = addr_q;
    assign bit_sel    = bitsel_q[BIT_IDX_W-1:0];
    assign bit_val    = |din_q;
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
    import otp_pkg::*;
#(
    parameter int                WORDS       = 1024,
    parameter int                IDX_W       = 10,
    parameter logic [WORD_W-1:0] SERIAL      = 32'h5EED_C0DE,
    parameter int                SERIAL_WORD = 252
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_start,
    input  logic [IDX_W-1:0]     word_addr,
    input  logic [BIT_IDX_W-1:0] bit_sel,
    input  logic                 bit_val,
    output logic [WORD_W-1:0]    rd_word,
    output logic                 prog_busy,
    output logic                 prog_reject
);
    logic [WORD_W-1:0]    fuse_q [WORDS];
    logic [WORD_W-1:0]    wmap_q [WORDS];
    logic [IDX_W-1:0]     tgt_addr;
    logic [BIT_IDX_W-1:0] tgt_bit;
    logic                 tgt_val;
    prog_state_t          state_q, state_d;
    logic                 flag_hit;
    logic                 do_commit;

    assign flag_hit = wmap_q[tgt_addr][tgt_bit];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE:  if (prog_start) state_d = PG_JUDGE;
            PG_JUDGE: state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        do_commit   = 1'b0;
        prog_reject = 1'b0;
        prog_busy   = 1'b0;
        unique case (state_q)
            PG_IDLE:  ;
            PG_JUDGE: begin
                prog_busy   = 1'b1;
                do_commit   = !flag_hit;
                prog_reject = flag_hit;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr <= '0;
            tgt_bit  <= '0;
            tgt_val  <= 1'b0;
        end else if (prog_start && state_q == PG_IDLE) begin
            tgt_addr <= word_addr;
            tgt_bit  <= bit_sel;
            tgt_val  <= bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                if (w == SERIAL_WORD)          fuse_q[w] <= SERIAL;
                else if (w == SERIAL_WORD + 1) fuse_q[w] <= ~SERIAL;
                else                           fuse_q[w] <= '1;
                wmap_q[w] <= '0;
            end
        end else if (do_commit) begin
            fuse_q[tgt_addr][tgt_bit] <= tgt_val;
            wmap_q[tgt_addr][tgt_bit] <= 1'b1;
        end
    end

    assign rd_word = fuse_q[word_addr];
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int                WORDS       = 1024,
    parameter logic [WORD_W-1:0] SERIAL      = 32'h5EED_C0DE,
    parameter int                SERIAL_WORD = 252,
    parameter logic [7:0]        OFF_DOUT    = 8'h00,
    parameter logic [7:0]        OFF_ADDR    = 8'h04,
    parameter logic [7:0]        OFF_BITSEL  = 8'h08,
    parameter logic [7:0]        OFF_DIN     = 8'h0C,
    parameter logic [7:0]        OFF_CE      = 8'h10,
    parameter logic [7:0]        OFF_STB     = 8'h14,
    parameter logic [7:0]        OFF_TRIM    = 8'h18,
    parameter logic [7:0]        OFF_WREN    = 8'h1C,
    parameter logic [7:0]        OFF_SPARE   = 8'h20,
    parameter logic [7:0]        OFF_TCLK    = 8'h24,
    parameter logic [7:0]        OFF_TMA     = 8'h28,
    parameter logic [7:0]        OFF_TMB     = 8'h2C,
    parameter logic [7:0]        OFF_TCTL    = 8'h30,
    parameter logic [7:0]        OFF_TREF    = 8'h34,
    parameter logic [7:0]        OFF_TPROG   = 8'h38
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        err_pulse
);
    localparam int IDX_W = $clog2(WORDS);

    logic [IDX_W-1:0]     word_addr;
    logic [BIT_IDX_W-1:0] bit_sel;
    logic                 bit_val;
    logic                 prog_start;
    logic                 prog_busy;
    logic                 prog_reject;
    logic                 rd_gate;
    logic                 spare_nz;
    logic [WORD_W-1:0]    fuse_word;

    otp_bus_regs #(
        .IDX_W(IDX_W), .OFF_DOUT(OFF_DOUT), .OFF_ADDR(OFF_ADDR), .OFF_BITSEL(OFF_BITSEL),
        .OFF_DIN(OFF_DIN), .OFF_CE(OFF_CE), .OFF_STB(OFF_STB), .OFF_TRIM(OFF_TRIM),
        .OFF_WREN(OFF_WREN), .OFF_SPARE(OFF_SPARE), .OFF_TCLK(OFF_TCLK), .OFF_TMA(OFF_TMA),
        .OFF_TMB(OFF_TMB), .OFF_TCTL(OFF_TCTL), .OFF_TREF(OFF_TREF), .OFF_TPROG(OFF_TPROG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .fuse_word(fuse_word),
        .prog_reject(prog_reject), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
        .word_addr(word_addr), .bit_sel(bit_sel), .bit_val(bit_val),
        .prog_start(prog_start), .rd_gate(rd_gate), .spare_nz(spare_nz)
    );

    otp_fuse_store #(
        .WORDS(WORDS), .IDX_W(IDX_W), .SERIAL(SERIAL), .SERIAL_WORD(SERIAL_WORD)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .word_addr(word_addr),
        .bit_sel(bit_sel), .bit_val(bit_val), .rd_word(fuse_word),
        .prog_busy(prog_busy), .prog_reject(prog_reject)
    );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
    parameter logic [7:0] OFF_DOUT   = 8'h00,
    parameter logic [7:0] OFF_ADDR   = 8'h04,
    parameter logic [7:0] OFF_BITSEL = 8'h08,
    parameter logic [7:0] OFF_DIN    = 8'h0C,
    parameter logic [7:0] OFF_CE     = 8'h10,
    parameter logic [7:0] OFF_STB    = 8'h14,
    parameter logic [7:0] OFF_TRIM   = 8'h18,
    parameter logic [7:0] OFF_WREN   = 8'h1C,
    parameter logic [7:0] OFF_SPARE  = 8'h20,
    parameter logic [7:0] OFF_TCLK   = 8'h24,
    parameter logic [7:0] OFF_TMA    = 8'h28,
    parameter logic [7:0] OFF_TMB    = 8'h2C,
    parameter logic [7:0] OFF_TCTL   = 8'h30,
    parameter logic [7:0] OFF_TREF   = 8'h34,
    parameter logic [7:0] OFF_TPROG  = 8'h38
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic [31:0] rsp_rdata,
    input logic        err_pulse,
    input logic        prog_busy,
    input logic        prog_reject,
    input logic        rd_gate,
    input logic        spare_nz
);
    logic known_off;
    assign known_off = (req_addr == OFF_DOUT)  || (req_addr == OFF_ADDR)  ||
                       (req_addr == OFF_BITSEL)|| (req_addr == OFF_DIN)   ||
                       (req_addr == OFF_CE)    || (req_addr == OFF_STB)   ||
                       (req_addr == OFF_TRIM)  || (req_addr == OFF_WREN)  ||
                       (req_addr == OFF_SPARE) || (req_addr == OFF_TCLK)  ||
                       (req_addr == OFF_TMA)   || (req_addr == OFF_TMB)   ||
                       (req_addr == OFF_TCTL)  || (req_addr == OFF_TREF)  ||
                       (req_addr == OFF_TPROG);

    assert_dout_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFF_DOUT && !rd_gate) |=> rsp_rdata == 32'h0000_00FF);

    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !known_off) |=> rsp_rdata == 32'h0);

    assert_unmapped_write_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !known_off) |=> err_pulse);

    assert_refusal_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_reject |=> err_pulse);

    assert_judge_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> $past(req_valid && req_write && req_addr == OFF_WREN && req_wdata[0]));

    assert_judge_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> !prog_busy);

    assert_spare_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_WREN && spare_nz && !prog_busy) |=> !prog_busy);

    assert_dout_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_DOUT && !prog_busy) |=> !err_pulse);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .OFF_DOUT(OFF_DOUT), .OFF_ADDR(OFF_ADDR), .OFF_BITSEL(OFF_BITSEL), .OFF_DIN(OFF_DIN),
    .OFF_CE(OFF_CE), .OFF_STB(OFF_STB), .OFF_TRIM(OFF_TRIM), .OFF_WREN(OFF_WREN),
    .OFF_SPARE(OFF_SPARE), .OFF_TCLK(OFF_TCLK), .OFF_TMA(OFF_TMA), .OFF_TMB(OFF_TMB),
    .OFF_TCTL(OFF_TCTL), .OFF_TREF(OFF_TREF), .OFF_TPROG(OFF_TPROG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .prog_busy(prog_busy), .prog_reject(prog_reject),
    .rd_gate(rd_gate), .spare_nz(spare_nz)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DOUT = 8'h00, A_ADDR = 8'h04, A_BITSEL = 8'h08, A_DIN = 8'h0C;
    localparam logic [7:0] A_CE = 8'h10, A_STB = 8'h14, A_TRIM = 8'h18, A_WREN = 8'h1C;
    localparam logic [7:0] A_SPARE = 8'h20, A_TMA = 8'h28, A_TPROG = 8'h38, A_HOLE = 8'h7C;
    localparam logic [31:0] SER = 32'h5EED_C0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        err_pulse;
    int          n_checks = 0;
    int          n_errors = 0;

    otp_fuse_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write: request is sampled at one edge; returns at the negedge after it.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    // Burn one bit; returns once the burn is judged and err_pulse is visible.
    task automatic burn(input int word, input int bitpos, input logic [31:0] din, output logic err);
        wr(A_ADDR, word);
        wr(A_BITSEL, bitpos);
        wr(A_DIN, din);
        wr(A_WREN, 32'h1);
        @(negedge clk);
        err = err_pulse;
    endtask

    task automatic t_reset_state;
        check(rsp_rdata === 32'h0 && err_pulse === 1'b0, "R8 outputs after reset", rsp_rdata, 32'h0);
        expect_rd(A_DOUT, 32'h0000_00FF, "R3 dout closed at reset");
        expect_rd(A_ADDR, 32'h0, "R8 address register reset");
    endtask

    task automatic t_serial_and_blank;
        wr(A_CE, 32'h1); wr(A_STB, 32'h1); wr(A_TRIM, 32'h1);
        wr(A_ADDR, 252);
        expect_rd(A_DOUT, SER, "R8 serial word");
        wr(A_ADDR, 253);
        expect_rd(A_DOUT, ~SER, "R8 serial complement");
        wr(A_ADDR, 5);
        expect_rd(A_DOUT, 32'hFFFF_FFFF, "R8 blank word");
    endtask

    task automatic t_read_hold;
        logic [31:0] v;
        wr(A_TMA, 32'hCAFE_0001);
        rd(A_TMA, v);
        wr(A_TPROG, 32'h1111_2222);
        @(negedge clk);
        check(rsp_rdata === 32'hCAFE_0001, "R1 read data holds across writes", rsp_rdata, 32'hCAFE_0001);
    endtask

    task automatic t_addr_mask;
        wr(A_ADDR, 32'hFFFF_F405);
        expect_rd(A_ADDR, 32'h0000_0005, "R2 address masked to 10 bits");
        expect_rd(A_DOUT, 32'hFFFF_FFFF, "R2 masked address selects word 5");
    endtask

    task automatic t_storage;
        wr(A_TMA, 32'h1234_5678);
        expect_rd(A_TMA, 32'h1234_5678, "R9 test mode A storage");
        wr(A_DIN, 32'h8000_0001);
        expect_rd(A_DIN, 32'h8000_0001, "R9 data-in storage");
        wr(A_TPROG, 32'hDEAD_BEEF);
        expect_rd(A_TPROG, 32'hDEAD_BEEF, "R9 program timing storage");
    endtask

    task automatic t_dout_write;
        wr(A_ADDR, 252);
        wr(A_DOUT, 32'h0);
        check(err_pulse === 1'b0, "R4 no error on dout write", {31'b0, err_pulse}, 32'h0);
        expect_rd(A_DOUT, SER, "R4 dout write ignored");
    endtask

    task automatic t_program;
        logic e;
        burn(5, 3, 32'h0, e);
        check(e === 1'b0, "R5 clean burn has no error", {31'b0, e}, 32'h0);
        expect_rd(A_DOUT, 32'hFFFF_FFF7, "R5 bit 3 of word 5 cleared");
        wr(A_WREN, 32'hFFFF_FFFE);
        expect_rd(A_WREN, 32'h0, "R5 enable keeps bit 0 only");
        burn(8, 32'h27, 32'h0, e);
        expect_rd(A_DOUT, 32'hFFFF_FF7F, "R5 bit select uses low five bits");
        burn(252, 0, 32'h7, e);
        expect_rd(A_DOUT, SER | 32'h1, "R5 nonzero data-in burns a one");
        expect_rd(A_WREN, 32'h1, "R5 enable readback");
    endtask

    task automatic t_write_once;
        logic e;
        burn(5, 3, 32'h1, e);
        check(e === 1'b1, "R6 second burn flagged", {31'b0, e}, 32'h1);
        @(negedge clk);
        check(err_pulse === 1'b0, "R6 error lasts one cycle", {31'b0, err_pulse}, 32'h0);
        wr(A_ADDR, 5);
        expect_rd(A_DOUT, 32'hFFFF_FFF7, "R6 refused burn leaves word");
        burn(5, 4, 32'h0, e);
        check(e === 1'b0, "R6 neighbour bit still free", {31'b0, e}, 32'h0);
        expect_rd(A_DOUT, 32'hFFFF_FFE7, "R6 neighbour bit burned");
    endtask

    task automatic t_spare;
        logic e;
        wr(A_SPARE, 32'h1);
        burn(7, 0, 32'h0, e);
        check(e === 1'b0, "R7 no error with spare set", {31'b0, e}, 32'h0);
        expect_rd(A_DOUT, 32'hFFFF_FFFF, "R7 no burn with spare set");
        expect_rd(A_WREN, 32'h1, "R7 enable register still updated");
        wr(A_SPARE, 32'h0);
        burn(7, 0, 32'h0, e);
        check(e === 1'b0, "R7 flag not set by blocked burn", {31'b0, e}, 32'h0);
        expect_rd(A_DOUT, 32'hFFFF_FFFE, "R7 later burn succeeds");
    endtask

    task automatic t_enables;
        wr(A_ADDR, 252);
        wr(A_TRIM, 32'h0);
        expect_rd(A_DOUT, 32'h0000_00FF, "R3 trim low closes dout");
        wr(A_TRIM, 32'h1); wr(A_STB, 32'h2);
        expect_rd(A_DOUT, 32'h0000_00FF, "R3 strobe bit 0 low closes dout");
        wr(A_STB, 32'h1); wr(A_CE, 32'h0);
        expect_rd(A_DOUT, 32'h0000_00FF, "R3 chip enable low closes dout");
        wr(A_CE, 32'h1);
        expect_rd(A_DOUT, SER | 32'h1, "R3 all enables open dout");
    endtask

    task automatic t_unmapped;
        wr(A_HOLE, 32'hFFFF_FFFF);
        check(err_pulse === 1'b1, "R10 unmapped write flagged", {31'b0, err_pulse}, 32'h1);
        @(negedge clk);
        check(err_pulse === 1'b0, "R10 flag lasts one cycle", {31'b0, err_pulse}, 32'h0);
        expect_rd(A_HOLE, 32'h0, "R10 unmapped read is zero");
        expect_rd(A_ADDR, 32'd252, "R10 unmapped write changed nothing");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_serial_and_blank();
        t_read_hold();
        t_addr_mask();
        t_storage();
        t_dout_write();
        t_program();
        t_write_once();
        t_spare();
        t_enables();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule